// File: doc/BRIEF.md
# Flash Erase Command Interface

This block is the command front end of a parallel NOR-style flash device. It watches host write cycles (address, data byte, write strobe) for two six-write command sequences: one erases the whole array, the other erases chosen sectors. Each sequence is two unlock writes, a set-up write, two more unlock writes and a final erase code. The unlock pattern is 0xAA to address 0x555, then 0x55 to address 0x2AA. The set-up code is 0x80 at 0x555. The final code is 0x10 at 0x555 for the whole array, or 0x30 at any address inside the target sector.

After a sector erase sequence, an acceptance window of `WIN_CYC` clock cycles opens. During the window the host may add more sectors, in any order, by writing 0x30. Each added sector restarts the window. When the window runs out, an internal sequencer works through the selected sectors in ascending index order. For each sector it preprograms the cell model to 0x00, verifies the zero pattern, and then erases the sector to 0xFF. The host provides no timing during this work.

While the device is busy, reads return a status byte instead of array data, and the ready/busy output is low. An asynchronous hardware reset aborts any operation at once. The cell array is modelled as one byte per sector, reset to a fixed preset pattern, and each array step is modelled by a cycle counter.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `ready_busy` is 1 and `rdata` is 0x00. Sector `s` holds the preset byte 0xA0+s.
- R2: In array-read mode, a read strobe returns the byte of the sector selected by `addr[ADDR_W-1 -: SECT_W]`, registered in the cycle after the strobe.
- R3: A whole-array sequence (AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555) makes the device busy from the edge that takes the sixth write. Afterwards every sector reads 0xFF.
- R4: A sector sequence whose sixth write is 0x30 selects the sector of that write's address. It opens a window of `WIN_CYC` cycles, during which `ready_busy` is 0 and no sector is touched.
- R5: Each 0x30 write inside the window adds its sector and restarts the window. Sectors may be added in any order, and only the selected sectors are erased.
- R6: Each selected sector takes `PROG_CYC` cycles of preprogramming to 0x00, one verify cycle that must see 0x00, and `ERASE_CYC` cycles of erase. Busy therefore ends exactly `WIN_CYC` (sector erase only) plus n×(`PROG_CYC`+1+`ERASE_CYC`) cycles after the last accepted write.
- R7: A write that breaks the expected address/data pattern of the sequence returns the decoder to idle with no operation started.
- R8: Any write other than 0x30 inside the window cancels the selection. `ready_busy` returns to 1 after that edge, and no sector is erased.
- R9: Every write made while the sequencer is erasing is ignored.
- R10: Asserting `rst_n` during an erase ends it at once, with `ready_busy` at 1, and reads then return array data.
- R11: A read while busy returns a status byte. Bit 7 (data poll) is 0. Bit 6 inverts on every status read, starting at 0. Bit 3 is 0 in the window and 1 while erasing. Bits 5, 4, 1 and 0 are 0.
- R12: Status bit 2 starts at 0 for each operation and inverts only on status reads whose address falls in a selected sector.
- R13: After an operation completes, reads return array data again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| we | input | 1 | Write strobe, one cycle per bus write |
| addr | input | ADDR_W | Bus address for writes and reads |
| wdata | input | 8 | Write data byte |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data: array byte or status byte |
| ready_busy | output | 1 | 1 when ready, 0 while in the window or erasing |

## Verification
Read data appears in the cycle after the read strobe, so each read task samples at the falling edge that follows the capturing edge. The busy period is measured with a free-running cycle counter, starting at the falling edge after the write that started it. The bench then compares that length to `WIN_CYC` + n×(`PROG_CYC`+1+`ERASE_CYC`), or to the same without `WIN_CYC` for a whole-array erase. Status reads in the toggle scenario are placed after the window has run out and within one sector's erase time, so the expected bit 3 value is known. A cancelled window is checked at the falling edge right after the cancelling write, and again after a full window length.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0]  CMD_UNLK_A = 8'hAA;
  localparam logic [7:0]  CMD_UNLK_B = 8'h55;
  localparam logic [7:0]  CMD_SETUP  = 8'h80;
  localparam logic [7:0]  CMD_CHIP   = 8'h10;
  localparam logic [7:0]  CMD_SECT   = 8'h30;
  localparam logic [11:0] ADR_UNLK_A = 12'h555;
  localparam logic [11:0] ADR_UNLK_B = 12'h2AA;

  typedef enum logic [2:0] {
    D_IDLE, D_U1, D_U2, D_SETUP, D_U4, D_U5, D_WIN
  } dec_st_t;

  typedef enum logic [1:0] {
    SQ_IDLE, SQ_PRE, SQ_VER, SQ_ERA
  } seq_st_t;

  // Preset content of a sector after hardware reset.
  function automatic logic [7:0] init_byte(input int idx);
    return 8'hA0 | 8'(idx);
  endfunction

  // Status byte: poll bit 7 low, toggle bit 6, erase-phase bit 3, sector toggle bit 2.
  function automatic logic [7:0] status_byte(input logic tog, input logic erasing,
                                             input logic stog);
    return {1'b0, tog, 2'b00, erasing, stog, 2'b00};
  endfunction

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_SECT = 8,
  parameter int WIN_CYC  = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          wdata,
  input  logic                seq_busy,
  output logic                launch,
  output logic [NUM_SECT-1:0] launch_mask,
  output logic                in_window,
  output logic [NUM_SECT-1:0] win_mask
);
  localparam int SECT_W = $clog2(NUM_SECT);
  localparam int WCNT_W = $clog2(WIN_CYC + 1);

  dec_st_t             st_q, st_n;
  logic [WCNT_W-1:0]   cnt_q, cnt_n;
  logic [NUM_SECT-1:0] mask_q, mask_n;
  logic [SECT_W-1:0]   wr_sect;
  logic [NUM_SECT-1:0] wr_onehot;
  logic hit_a, hit_b, hit_setup, hit_chip, hit_sect;
  logic chip_go, sect_go;

  assign wr_sect   = addr[ADDR_W-1 -: SECT_W];
  assign wr_onehot = NUM_SECT'(1) << wr_sect;
  assign hit_a     = (addr == ADDR_W'(ADR_UNLK_A)) && (wdata == CMD_UNLK_A);
  assign hit_b     = (addr == ADDR_W'(ADR_UNLK_B)) && (wdata == CMD_UNLK_B);
  assign hit_setup = (addr == ADDR_W'(ADR_UNLK_A)) && (wdata == CMD_SETUP);
  assign hit_chip  = (addr == ADDR_W'(ADR_UNLK_A)) && (wdata == CMD_CHIP);
  assign hit_sect  = (wdata == CMD_SECT);

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    mask_n  = mask_q;
    chip_go = 1'b0;
    sect_go = 1'b0;
    unique case (st_q)
      D_IDLE:  if (we && !seq_busy) st_n = hit_a ? D_U1 : D_IDLE;
      D_U1:    if (we) st_n = hit_b ? D_U2 : D_IDLE;
      D_U2:    if (we) st_n = hit_setup ? D_SETUP : D_IDLE;
      D_SETUP: if (we) st_n = hit_a ? D_U4 : D_IDLE;
      D_U4:    if (we) st_n = hit_b ? D_U5 : D_IDLE;
      D_U5: begin
        if (we) begin
          st_n = D_IDLE;
          if (hit_chip) begin
            chip_go = 1'b1;
          end else if (hit_sect) begin
            st_n   = D_WIN;
            mask_n = wr_onehot;
            cnt_n  = WCNT_W'(WIN_CYC);
          end
        end
      end
      D_WIN: begin
        if (we) begin
          if (hit_sect) begin
            mask_n = mask_q | wr_onehot;
            cnt_n  = WCNT_W'(WIN_CYC);
          end else begin
            st_n   = D_IDLE;
            mask_n = '0;
          end
        end else if (cnt_q == WCNT_W'(1)) begin
          sect_go = 1'b1;
          st_n    = D_IDLE;
          mask_n  = '0;
        end else begin
          cnt_n = cnt_q - WCNT_W'(1);
        end
      end
      default: st_n = D_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= D_IDLE;
      cnt_q  <= '0;
      mask_q <= '0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      mask_q <= mask_n;
    end
  end

  assign launch      = chip_go || sect_go;
  assign launch_mask = chip_go ? {NUM_SECT{1'b1}} : mask_q;
  assign in_window   = (st_q == D_WIN);
  assign win_mask    = mask_q;

  AST_WIN_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == D_WIN) |-> (cnt_q != '0 && mask_q != '0)); // R4

  AST_IDLE_WHILE_ERASING: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> (st_q == D_IDLE)); // R9

  AST_CANCEL_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_window && we && !hit_sect) |=> (st_q == D_IDLE && !seq_busy)); // R8

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_cmd_pkg::*;
#(
  parameter int NUM_SECT  = 8,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        launch,
  input  logic [NUM_SECT-1:0]         launch_mask,
  input  logic [$clog2(NUM_SECT)-1:0] rd_sect,
  output logic [7:0]                  rd_byte,
  output logic                        busy,
  output logic [NUM_SECT-1:0]         pend_mask
);
  localparam int SECT_W = $clog2(NUM_SECT);
  localparam int MAXC   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W  = $clog2(MAXC + 1);

  function automatic logic [SECT_W-1:0] first_set(input logic [NUM_SECT-1:0] m);
    first_set = '0;
    for (int i = NUM_SECT - 1; i >= 0; i--) begin
      if (m[i]) first_set = SECT_W'(i);
    end
  endfunction

  seq_st_t             st_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [NUM_SECT-1:0] pend_q;
  logic [7:0]          arr_q [NUM_SECT];
  logic [SECT_W-1:0]   cur;
  logic                verify_ok;
  logic [NUM_SECT-1:0] rest;

  assign cur       = first_set(pend_q);
  assign verify_ok = (arr_q[cur] == 8'h00);
  assign rest      = pend_q & ~(NUM_SECT'(1) << cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      pend_q <= '0;
      for (int i = 0; i < NUM_SECT; i++) arr_q[i] <= init_byte(i);
    end else begin
      unique case (st_q)
        SQ_IDLE: if (launch) begin
          pend_q <= launch_mask;
          st_q   <= SQ_PRE;
          cnt_q  <= CNT_W'(PROG_CYC - 1);
        end
        SQ_PRE: if (cnt_q == '0) begin
          arr_q[cur] <= 8'h00;
          st_q       <= SQ_VER;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
        SQ_VER: if (verify_ok) begin
          st_q  <= SQ_ERA;
          cnt_q <= CNT_W'(ERASE_CYC - 1);
        end else begin
          st_q  <= SQ_PRE;
          cnt_q <= CNT_W'(PROG_CYC - 1);
        end
        SQ_ERA: if (cnt_q == '0) begin
          arr_q[cur] <= 8'hFF;
          pend_q     <= rest;
          if (rest != '0) begin
            st_q  <= SQ_PRE;
            cnt_q <= CNT_W'(PROG_CYC - 1);
          end else begin
            st_q <= SQ_IDLE;
          end
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != SQ_IDLE);
  assign pend_mask = pend_q;
  assign rd_byte   = arr_q[rd_sect];

  AST_ERASE_AFTER_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_ERA && $past(st_q) != SQ_ERA) |-> ($past(st_q) == SQ_VER && $past(verify_ok))); // R6

  AST_LAUNCH_HAS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && st_q == SQ_IDLE) |-> (launch_mask != '0)); // R5

endmodule

// File: rtl/flash_status_rd.sv
module flash_status_rd
  import flash_cmd_pkg::*;
#(
  parameter int NUM_SECT = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd,
  input  logic [$clog2(NUM_SECT)-1:0] rd_sect,
  input  logic                        busy,
  input  logic                        erasing,
  input  logic [NUM_SECT-1:0]         sel_mask,
  input  logic [7:0]                  arr_byte,
  output logic [7:0]                  rdata
);
  logic tog_q, stog_q;
  logic sel_hit;

  assign sel_hit = sel_mask[rd_sect];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= 8'h00;
      tog_q  <= 1'b0;
      stog_q <= 1'b0;
    end else if (!busy) begin
      tog_q  <= 1'b0;
      stog_q <= 1'b0;
      if (rd) rdata <= arr_byte;
    end else if (rd) begin
      rdata <= status_byte(tog_q, erasing, stog_q);
      tog_q <= ~tog_q;
      if (sel_hit) stog_q <= ~stog_q;
    end
  end

  AST_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && busy) |=> (rdata[7] == 1'b0)); // R11

  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && busy) |=> (tog_q != $past(tog_q))); // R11

  AST_STOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(rd && sel_hit)) |=> $stable(stog_q)); // R12

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_SECT  = 8,
  parameter int WIN_CYC   = 20,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              rd,
  output logic [7:0]        rdata,
  output logic              ready_busy
);
  localparam int SECT_W = $clog2(NUM_SECT);

  logic                launch;
  logic [NUM_SECT-1:0] launch_mask;
  logic                in_window;
  logic [NUM_SECT-1:0] win_mask;
  logic                seq_busy;
  logic [NUM_SECT-1:0] pend_mask;
  logic [NUM_SECT-1:0] sel_mask;
  logic [SECT_W-1:0]   rd_sect;
  logic [7:0]          arr_byte;
  logic                busy;

  assign rd_sect  = addr[ADDR_W-1 -: SECT_W];
  assign busy     = in_window || seq_busy;
  assign sel_mask = in_window ? win_mask : pend_mask;

  flash_cmd_decode #(
    .ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT), .WIN_CYC(WIN_CYC)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .seq_busy(seq_busy), .launch(launch), .launch_mask(launch_mask),
    .in_window(in_window), .win_mask(win_mask)
  );

  flash_erase_seq #(
    .NUM_SECT(NUM_SECT), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_mask(launch_mask),
    .rd_sect(rd_sect), .rd_byte(arr_byte), .busy(seq_busy), .pend_mask(pend_mask)
  );

  flash_status_rd #(
    .NUM_SECT(NUM_SECT)
  ) u_stat (
    .clk(clk), .rst_n(rst_n), .rd(rd), .rd_sect(rd_sect), .busy(busy),
    .erasing(seq_busy), .sel_mask(sel_mask), .arr_byte(arr_byte), .rdata(rdata)
  );

  assign ready_busy = !busy;

  AST_LAUNCH_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !ready_busy); // R3

endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12, NS = 8, WIN = 20, PROG = 4, ERA = 16;
  localparam int PER = PROG + 1 + ERA;

  logic clk = 0, rst_n = 0, we = 0, rd = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic ready_busy;
  int cyc = 0, checks = 0, errors = 0, t0 = 0;
  logic [7:0] rv;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W), .NUM_SECT(NS), .WIN_CYC(WIN),
                   .PROG_CYC(PROG), .ERASE_CYC(ERA)) dut (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .rd(rd), .rdata(rdata), .ready_busy(ready_busy));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic logic [ADDR_W-1:0] sa(input int s);
    return ADDR_W'(s) << (ADDR_W - 3);
  endfunction
  function automatic logic [7:0] preset(input int s);
    return 8'hA0 + 8'(s);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; we = 0; rd = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rdb(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic seq6(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(a, d);
    t0 = cyc;
  endtask

  task automatic wait_ready(output int dur);
    while (!ready_busy) @(negedge clk);
    dur = cyc - t0;
  endtask

  task automatic t_reset_and_read();
    chk("R1 ready after reset", ready_busy, 1);
    chk("R1 rdata after reset", rdata, 0);
    for (int s = 0; s < NS; s++) begin
      rdb(sa(s) | 12'h013, rv);
      chk("R2 array read", rv, preset(s));
    end
  endtask

  task automatic t_break();
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h90);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h10);
    chk("R7 no op after broken pattern", ready_busy, 1);
    rdb(sa(0), rv);
    chk("R7 data intact", rv, preset(0));
  endtask

  task automatic t_chip();
    int d;
    seq6(12'h555, 8'h10);
    chk("R3 busy after sixth write", ready_busy, 0);
    wait_ready(d);
    chk("R6 chip erase duration", d, NS * PER);
    for (int s = 0; s < NS; s++) begin
      rdb(sa(s), rv);
      chk("R13 R3 erased byte", rv, 8'hFF);
    end
  endtask

  task automatic t_single();
    int d;
    do_reset();
    seq6(sa(3) | 12'h044, 8'h30);
    chk("R4 busy in window", ready_busy, 0);
    wait_ready(d);
    chk("R4 window plus one sector", d, WIN + PER);
    rdb(sa(3), rv); chk("R4 target erased", rv, 8'hFF);
    rdb(sa(4), rv); chk("R13 neighbour intact", rv, preset(4));
  endtask

  task automatic t_multi();
    int d;
    do_reset();
    seq6(sa(5), 8'h30);
    repeat (4) @(negedge clk);
    wr(sa(1), 8'h30);
    repeat (7) @(negedge clk);
    wr(sa(6), 8'h30);
    t0 = cyc;
    wait_ready(d);
    chk("R5 duration from last add", d, WIN + 3 * PER);
    for (int s = 0; s < NS; s++) begin
      rdb(sa(s), rv);
      chk("R5 selection", rv, (s == 1 || s == 5 || s == 6) ? 8'hFF : preset(s));
    end
  endtask

  task automatic t_cancel();
    do_reset();
    seq6(sa(2), 8'h30);
    repeat (3) @(negedge clk);
    wr(sa(2), 8'hF0);
    chk("R8 ready after cancel", ready_busy, 1);
    repeat (WIN + 5) @(negedge clk);
    chk("R8 still ready", ready_busy, 1);
    rdb(sa(2), rv);
    chk("R8 sector untouched", rv, preset(2));
  endtask

  task automatic t_ignore();
    int d;
    do_reset();
    seq6(sa(0), 8'h30);
    repeat (WIN) @(negedge clk);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h10);
    wait_ready(d);
    chk("R9 duration unchanged", d, WIN + PER);
    rdb(sa(1), rv); chk("R9 chip command ignored", rv, preset(1));
    chk("R9 ready afterwards", ready_busy, 1);
  endtask

  task automatic t_status();
    int d;
    do_reset();
    seq6(sa(1), 8'h30);
    rdb(sa(4), rv); chk("R11 window status first", rv, 8'h00);
    rdb(sa(4), rv); chk("R11 window status second", rv, 8'h40);
    wait_ready(d);
    do_reset();
    seq6(sa(2), 8'h30);
    repeat (WIN) @(negedge clk);
    rdb(sa(2), rv); chk("R11 erase status", rv, 8'h08);
    rdb(sa(6), rv); chk("R12 unselected read", rv, 8'h4C);
    rdb(sa(6), rv); chk("R12 unselected holds", rv, 8'h0C);
    rdb(sa(2), rv); chk("R12 selected read", rv, 8'h4C);
    wait_ready(d);
    rdb(sa(2), rv); chk("R13 array after status", rv, 8'hFF);
  endtask

  task automatic t_abort();
    do_reset();
    seq6(12'h555, 8'h10);
    repeat (30) @(negedge clk);
    rst_n = 0;
    #1 chk("R10 ready during reset", ready_busy, 1);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 ready after abort", ready_busy, 1);
    rdb(sa(0), rv); chk("R10 array read after abort", rv, preset(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_and_read();
    t_break();
    t_chip();
    t_single();
    t_multi();
    t_cancel();
    t_ignore();
    t_status();
    t_abort();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule